// File: doc/BRIEF.md
# Timer Event Capture and Interrupt Unit

This block sits beside a free-running 64-bit time counter and turns asynchronous external happenings and time comparisons into flagged events and a single interrupt request. Each external trigger input is synchronized. On its selected edge, the block freezes the current 64-bit time into a per-trigger snapshot register and raises that trigger's event flag. Each alarm holds a 64-bit compare value. It raises its own event flag once, when the time counter reaches or passes that value.

Software drives the block through a plain write port. A control register picks the active edge of each trigger. The event register is cleared by writing ones. The mask register chooses which flags may raise the interrupt. The alarm words are written low word first and high word last. The write to the low word disarms the alarm and the write to the high word arms it. Periodic alarms are therefore built in software: after a match, the old value plus the interval is written back.

Top module: `tsu_event_unit`

## Requirements
- R1: After reset the event register, the interrupt and every timestamp read zero.
- R2: With control bit 8+k at 0, a rising edge on trigger k is seen after a two-flop synchronizer. The flag in event bit 24+k and the time in timestamp k are visible three clock edges after the input changes. The timestamp holds the 64-bit time sampled on that third edge.
- R3: With control bit 8+k at 1, trigger k captures on the falling edge only, and its rising edge changes neither the flag nor the timestamp.
- R4: A write to address 1 clears each event bit written as one, and leaves bits written as zero unchanged.
- R5: A capture and a clear of the same event bit on the same edge leave the bit set.
- R6: A new capture while the trigger's flag is still set overwrites the timestamp with the new time.
- R7: Alarm a fires at most once per arming, on the first edge where time is greater than or equal to its 64-bit value, and sets event bit 16+a.
- R8: Alarm a's low word is at address 4+2a and its high word at 5+2a. Writing the low word disarms the alarm, and writing the high word arms it. The compare spans all 64 bits, so rewriting both words rearms the alarm for a later time.
- R9: Mask bits share the event bit positions (address 2). The interrupt is high exactly when a masked-in event is pending, in the same cycle in the default combinational mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_i | input | 64 | Current time counter value |
| trig_i | input | 2 | Asynchronous trigger inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| event_o | output | 32 | Event register contents |
| irq_o | output | 1 | Interrupt request |
| ts_o | output | 128 | Snapshots, trigger k at bits 64k+63..64k |

## Verification
A synchronizer or edge detector with the wrong depth or sense moves the event bit to a different cycle from the third edge, or makes it answer the wrong edge. The bench catches this within four cycles of a trigger change. A stuck or missing alarm arm state shows as a flag that never rises, or one that returns after being cleared while time stays past the compare value. Faulty clear logic leaves a stale or lost flag. Because the bit feeds the interrupt, this is visible on the next edge.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
   localparam int EVT_ALM_BASE  = 16;
   localparam int EVT_TRIG_BASE = 24;
   localparam int CTRL_POL_BASE = 8;
   localparam int REG_CTRL      = 0;
   localparam int REG_EVENT     = 1;
   localparam int REG_MASK      = 2;
   localparam int REG_ALM_BASE  = 4;
endpackage

// File: rtl/tsu_trig_capture.sv
module tsu_trig_capture #(
   parameter int TIME_W      = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              fall_sel_i,
   input  logic [TIME_W-1:0] time_i,
   output logic              cap_stb_o,
   output logic [TIME_W-1:0] ts_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   lvl;
   logic [TIME_W-1:0]      ts_q;

   assign lvl       = sync_q[SYNC_STAGES-1];
   assign cap_stb_o = fall_sel_i ? (~lvl & prev_q) : (lvl & ~prev_q);
   assign ts_o      = ts_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
         ts_q   <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], trig_i};
         prev_q <= lvl;
         if (cap_stb_o) ts_q <= time_i;
      end
   end
endmodule

// File: rtl/tsu_alarm_cmp.sv
module tsu_alarm_cmp #(
   parameter int DATA_W = 32,
   localparam int TIME_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [TIME_W-1:0] time_i,
   output logic              hit_o
);
   logic [TIME_W-1:0] alm_q;
   logic              armed_q;

   assign hit_o = armed_q && (time_i >= alm_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         if (wr_lo_i) begin
            alm_q[DATA_W-1:0] <= wdata_i;
            armed_q           <= 1'b0;
         end else if (wr_hi_i) begin
            alm_q[TIME_W-1:DATA_W] <= wdata_i;
            armed_q                <= 1'b1;
         end else if (hit_o) begin
            armed_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tsu_event_regs.sv
module tsu_event_regs
   import tsu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int N_TRIG  = 2,
   parameter int N_ALARM = 2,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_TRIG-1:0]  trig_set_i,
   input  logic [N_ALARM-1:0] alm_set_i,
   input  logic               clr_en_i,
   input  logic               mask_we_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  event_o,
   output logic               irq_o
);
   function automatic logic [DATA_W-1:0] valid_bits();
      logic [DATA_W-1:0] v;
      v = '0;
      for (int k = 0; k < N_TRIG; k++)  v[EVT_TRIG_BASE+k] = 1'b1;
      for (int a = 0; a < N_ALARM; a++) v[EVT_ALM_BASE+a]  = 1'b1;
      return v;
   endfunction

   localparam logic [DATA_W-1:0] VALID_MASK = valid_bits();

   logic [DATA_W-1:0] ev_q, msk_q, set_vec, clr_vec;

   always_comb begin
      set_vec = '0;
      for (int k = 0; k < N_TRIG; k++)  set_vec[EVT_TRIG_BASE+k] = trig_set_i[k];
      for (int a = 0; a < N_ALARM; a++) set_vec[EVT_ALM_BASE+a]  = alm_set_i[a];
      clr_vec = clr_en_i ? wdata_i : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q  <= '0;
         msk_q <= '0;
      end else begin
         ev_q <= ((ev_q & ~clr_vec) | set_vec) & VALID_MASK;
         if (mask_we_i) msk_q <= wdata_i & VALID_MASK;
      end
   end

   assign event_o = ev_q;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(ev_q & msk_q);
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = |(ev_q & msk_q);
   end
endmodule

// File: rtl/tsu_event_unit.sv
module tsu_event_unit
   import tsu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int N_TRIG      = 2,
   parameter int N_ALARM     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 4,
   parameter bit IRQ_REG     = 1'b0,
   localparam int TIME_W     = 2 * DATA_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [TIME_W-1:0]        time_i,
   input  logic [N_TRIG-1:0]        trig_i,
   input  logic                     wr_en_i,
   input  logic [ADDR_W-1:0]        wr_addr_i,
   input  logic [DATA_W-1:0]        wr_data_i,
   output logic [DATA_W-1:0]        event_o,
   output logic                     irq_o,
   output logic [N_TRIG*TIME_W-1:0] ts_o
);
   if (N_TRIG < 1 || N_TRIG > 8) begin : g_bad_trig
      $error("tsu_event_unit: N_TRIG must be 1..8");
   end
   if (N_ALARM < 1 || N_ALARM > 8) begin : g_bad_alarm
      $error("tsu_event_unit: N_ALARM must be 1..8");
   end
   if (EVT_TRIG_BASE + N_TRIG > DATA_W) begin : g_bad_width
      $error("tsu_event_unit: DATA_W too narrow for event layout");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tsu_event_unit: SYNC_STAGES must be at least 2");
   end
   if (REG_ALM_BASE + 2 * N_ALARM > (1 << ADDR_W)) begin : g_bad_addr
      $error("tsu_event_unit: ADDR_W too narrow for alarm registers");
   end

   logic [N_TRIG-1:0]  pol_q;
   logic [N_TRIG-1:0]  cap_stb;
   logic [N_ALARM-1:0] alm_hit;
   logic               ctrl_we, clr_en, mask_we;

   assign ctrl_we = wr_en_i && (wr_addr_i == ADDR_W'(REG_CTRL));
   assign clr_en  = wr_en_i && (wr_addr_i == ADDR_W'(REG_EVENT));
   assign mask_we = wr_en_i && (wr_addr_i == ADDR_W'(REG_MASK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pol_q <= '0;
      else if (ctrl_we) pol_q <= wr_data_i[CTRL_POL_BASE +: N_TRIG];
   end

   for (genvar k = 0; k < N_TRIG; k++) begin : g_trig
      tsu_trig_capture #(
         .TIME_W      (TIME_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_cap (
         .clk        (clk),
         .rst_n      (rst_n),
         .trig_i     (trig_i[k]),
         .fall_sel_i (pol_q[k]),
         .time_i     (time_i),
         .cap_stb_o  (cap_stb[k]),
         .ts_o       (ts_o[k*TIME_W +: TIME_W])
      );
   end

   for (genvar a = 0; a < N_ALARM; a++) begin : g_alarm
      logic wr_lo, wr_hi;
      assign wr_lo = wr_en_i && (wr_addr_i == ADDR_W'(REG_ALM_BASE + 2*a));
      assign wr_hi = wr_en_i && (wr_addr_i == ADDR_W'(REG_ALM_BASE + 2*a + 1));
      tsu_alarm_cmp #(
         .DATA_W (DATA_W)
      ) u_alm (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_lo_i (wr_lo),
         .wr_hi_i (wr_hi),
         .wdata_i (wr_data_i),
         .time_i  (time_i),
         .hit_o   (alm_hit[a])
      );
   end

   tsu_event_regs #(
      .DATA_W  (DATA_W),
      .N_TRIG  (N_TRIG),
      .N_ALARM (N_ALARM),
      .IRQ_REG (IRQ_REG)
   ) u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_set_i (cap_stb),
      .alm_set_i  (alm_hit),
      .clr_en_i   (clr_en),
      .mask_we_i  (mask_we),
      .wdata_i    (wr_data_i),
      .event_o    (event_o),
      .irq_o      (irq_o)
   );
endmodule

// File: rtl/tsu_event_unit_chk.sv
module tsu_event_unit_chk
   import tsu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int N_TRIG  = 2,
   parameter int N_ALARM = 2,
   parameter int ADDR_W  = 4,
   parameter bit IRQ_REG = 1'b0,
   localparam int TIME_W = 2 * DATA_W
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [DATA_W-1:0]        event_o,
   input logic                     irq_o,
   input logic [N_TRIG*TIME_W-1:0] ts_o,
   input logic [N_TRIG-1:0]        cap_stb,
   input logic [N_ALARM-1:0]       alm_hit,
   input logic                     wr_en_i,
   input logic [ADDR_W-1:0]        wr_addr_i
);
   if (!IRQ_REG) begin : g_irq
      assert_irq_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> (event_o != '0));
   end

   for (genvar k = 0; k < N_TRIG; k++) begin : g_trig
      assert_ts_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !cap_stb[k] |=> $stable(ts_o[k*TIME_W +: TIME_W]));
      assert_evt_stays_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!event_o[EVT_TRIG_BASE+k] && !cap_stb[k]) |=> !event_o[EVT_TRIG_BASE+k]);
      assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
         cap_stb[k] |=> event_o[EVT_TRIG_BASE+k]);
   end

   for (genvar a = 0; a < N_ALARM; a++) begin : g_alm
      assert_alarm_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (alm_hit[a] && !(wr_en_i && wr_addr_i == ADDR_W'(REG_ALM_BASE + 2*a + 1)))
         |=> !alm_hit[a]);
      assert_alarm_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
         alm_hit[a] |=> event_o[EVT_ALM_BASE+a]);
   end
endmodule

bind tsu_event_unit tsu_event_unit_chk #(
   .DATA_W  (DATA_W),
   .N_TRIG  (N_TRIG),
   .N_ALARM (N_ALARM),
   .ADDR_W  (ADDR_W),
   .IRQ_REG (IRQ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .event_o   (event_o),
   .irq_o     (irq_o),
   .ts_o      (ts_o),
   .cap_stb   (cap_stb),
   .alm_hit   (alm_hit),
   .wr_en_i   (wr_en_i),
   .wr_addr_i (wr_addr_i)
);

// File: tb/tsu_event_unit_tb_top.sv
module tsu_event_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SEL_EVT = 0, SEL_IRQ = 1, SEL_TS0 = 2, SEL_TS1 = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [63:0]  time_i = '0;
   logic [1:0]   trig_i = '0;
   logic         wr_en_i = 1'b0;
   logic [3:0]   wr_addr_i = '0;
   logic [31:0]  wr_data_i = '0;
   logic [31:0]  event_o;
   logic         irq_o;
   logic [127:0] ts_o;

   tsu_event_unit dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .time_i    (time_i),
      .trig_i    (trig_i),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .event_o   (event_o),
      .irq_o     (irq_o),
      .ts_o      (ts_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          cyc;
      int          sel;
      logic [63:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   item_t keep[$];
   int    cyc = 0;
   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [63:0] observe(int sel);
      case (sel)
         SEL_EVT: return {32'b0, event_o};
         SEL_IRQ: return {63'b0, irq_o};
         SEL_TS0: return ts_o[63:0];
         default: return ts_o[127:64];
      endcase
   endfunction

   // monitor: compares every queued item that falls due on this cycle
   always @(negedge clk) begin
      keep = {};
      foreach (q[i]) begin
         if (q[i].cyc == cyc) begin
            n_checks++;
            if (observe(q[i].sel) !== q[i].exp) begin
               n_fail++;
               $display("FAIL %s sel=%0d actual=%h expected=%h", q[i].req, q[i].sel,
                        observe(q[i].sel), q[i].exp);
            end
         end else begin
            keep.push_back(q[i]);
         end
      end
      q = keep;
   end

   task automatic expect_at(int off, int sel, logic [63:0] v, string req);
      item_t it;
      it.cyc = cyc + off;
      it.sel = sel;
      it.exp = v;
      it.req = req;
      q.push_back(it);
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      wr_en_i   = 1'b1;
      wr_addr_i = a;
      wr_data_i = d;
      @(negedge clk);
      wr_en_i   = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   localparam logic [63:0] T1 = 64'h0000_0012_3456_789A;
   localparam logic [63:0] T2 = 64'hABCD_0000_0000_0055;
   localparam logic [63:0] T3 = 64'h0000_0777_0000_1000;
   localparam logic [63:0] T4 = 64'h0000_0777_0000_2000;

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R1 reset state
      expect_at(1, SEL_EVT, 0, "R1");
      expect_at(1, SEL_IRQ, 0, "R1");
      expect_at(1, SEL_TS0, 0, "R1");
      expect_at(1, SEL_TS1, 0, "R1");
      tick(1);

      // R2 rising capture latency
      time_i = T1;
      trig_i[0] = 1'b1;
      expect_at(2, SEL_EVT, 0, "R2 early");
      expect_at(3, SEL_EVT, 64'(1) << 24, "R2");
      expect_at(3, SEL_TS0, T1, "R2");
      expect_at(3, SEL_IRQ, 0, "R9 masked");
      tick(4);

      // R9 mask enables interrupt
      expect_at(1, SEL_IRQ, 1, "R9");
      wr(4'd2, 32'h0100_0000);

      // R4 write-one-to-clear
      expect_at(1, SEL_EVT, 64'(1) << 24, "R4 zero write");
      wr(4'd1, 32'h0);
      expect_at(1, SEL_EVT, 0, "R4");
      expect_at(1, SEL_IRQ, 0, "R4 irq");
      wr(4'd1, 32'h0100_0000);

      // R3 falling polarity on trigger 1
      wr(4'd0, 32'h0000_0200);
      time_i = T2;
      trig_i[1] = 1'b1;
      expect_at(4, SEL_EVT, 0, "R3 rising ignored");
      expect_at(4, SEL_TS1, 0, "R3 rising ignored");
      tick(5);
      trig_i[1] = 1'b0;
      expect_at(3, SEL_EVT, 64'(1) << 25, "R3");
      expect_at(3, SEL_TS1, T2, "R3");
      expect_at(3, SEL_IRQ, 0, "R9 bit25 masked");
      tick(4);

      // R6 overwrite while pending
      trig_i[0] = 1'b0;
      expect_at(4, SEL_EVT, 64'(1) << 25, "R3 falling ignored on rising trigger");
      tick(4);
      time_i = T3;
      trig_i[0] = 1'b1;
      expect_at(3, SEL_TS0, T3, "R6 first");
      tick(4);
      trig_i[0] = 1'b0;
      tick(4);
      time_i = T4;
      trig_i[0] = 1'b1;
      expect_at(3, SEL_TS0, T4, "R6");
      expect_at(3, SEL_EVT, 64'h0300_0000, "R6");
      tick(4);

      // R5 capture beats same-edge clear
      expect_at(1, SEL_EVT, 0, "R4 clear both");
      wr(4'd1, 32'h0300_0000);
      trig_i[0] = 1'b0;
      tick(4);
      trig_i[0] = 1'b1;
      expect_at(3, SEL_EVT, 64'(1) << 24, "R5");
      tick(2);
      wr(4'd1, 32'h0100_0000);
      expect_at(1, SEL_EVT, 0, "R4");
      wr(4'd1, 32'h0100_0000);

      // R7 alarm 0
      time_i = 64'd100;
      wr(4'd4, 32'd200);
      wr(4'd5, 32'd0);
      time_i = 64'd150;
      expect_at(1, SEL_EVT, 0, "R7 below");
      expect_at(3, SEL_EVT, 0, "R7 below");
      tick(3);
      time_i = 64'd200;
      expect_at(1, SEL_EVT, 64'(1) << 16, "R7 equal");
      tick(1);
      expect_at(1, SEL_EVT, 0, "R4 alarm clear");
      wr(4'd1, 32'h0001_0000);
      time_i = 64'd300;
      expect_at(3, SEL_EVT, 0, "R7 once");
      tick(3);

      // R8 low write disarms
      wr(4'd4, 32'd50);
      expect_at(3, SEL_EVT, 0, "R8 disarm");
      tick(3);

      // R8 64-bit compare on alarm 1
      time_i = 64'h0000_0000_FFFF_FFFF;
      wr(4'd6, 32'h10);
      wr(4'd7, 32'h1);
      expect_at(2, SEL_EVT, 0, "R8 high word");
      tick(2);
      time_i = 64'h0000_0001_0000_0010;
      expect_at(1, SEL_EVT, 64'(1) << 17, "R8");
      tick(1);
      wr(4'd1, 32'h0002_0000);
      wr(4'd6, 32'h20);
      wr(4'd7, 32'h1);
      expect_at(2, SEL_EVT, 0, "R8 reload");
      tick(2);
      time_i = 64'h0000_0001_0000_0020;
      expect_at(1, SEL_EVT, 64'(1) << 17, "R7 periodic");
      tick(1);
      wr(4'd1, 32'h0002_0000);
      wr(4'd6, 32'h30);
      wr(4'd7, 32'h1);
      time_i = 64'h0000_0001_0000_0100;
      expect_at(1, SEL_EVT, 64'(1) << 17, "R7 passed");
      tick(1);

      // R9 alarm mask
      expect_at(1, SEL_IRQ, 1, "R9 alarm");
      wr(4'd2, 32'h0002_0000);
      expect_at(1, SEL_IRQ, 0, "R9 unmask");
      wr(4'd2, 32'h0);

      tick(4);
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard left %0d items, expected 0", q.size());
      end
      finish_run();
   end
endmodule